// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns one single-word memory access into a memory request and, when the indexing mode calls for it, a base-register update. Each operation carries a base value, an offset, an add/subtract select, an indexing mode, a load/store flag, store data and a destination register index. The offset reaches the block already resolved, whether it came from an immediate field or from a second register, and both kinds are handled identically. The block computes the effective address and the writeback value with a single wrapping adder. It then issues a registered request on a valid/ready memory port. For loads it returns the response data together with the destination index.

Three indexing modes are supported. In offset mode the access goes to base plus or minus the offset and the base register is left unchanged. In pre-indexed mode the same computed address is used for the access and is also written back. The writeback pulse comes one cycle before the request is raised. In post-indexed mode the access goes to the unmodified base. Base plus or minus the offset is written back only in the cycle the memory handshake completes, so a stalled access leaves the base untouched. Mode encoding 2'b11 behaves as offset mode with no writeback. Memory is only ever reached by explicit load and store transfers, and nothing is modified in place.

The control is a four-state machine:
- `ST_IDLE` waits for an operation.
- `ST_PREWB` emits the pre-indexed writeback.
- `ST_REQ` holds the memory request until it is accepted.
- `ST_WAIT_RSP` waits for load data.

Its transitions are:
- ACCEPT_PRE: `ST_IDLE` to `ST_PREWB`, when a pre-indexed operation is accepted.
- ACCEPT_DIRECT: `ST_IDLE` to `ST_REQ`, when any other operation is accepted.
- PREWB_DONE: `ST_PREWB` to `ST_REQ`, always.
- STORE_DONE: `ST_REQ` to `ST_IDLE`, when a store handshake completes.
- LOAD_ISSUED: `ST_REQ` to `ST_WAIT_RSP`, when a load handshake completes.
- LOAD_DONE: `ST_WAIT_RSP` to `ST_IDLE`, when the load response arrives.

Top module: `lsagu_top`

## Requirements
- R1: With `op_mode` = 2'b00 (offset), `mem_req_addr` equals base plus or minus offset, and `wb_en` never asserts for that operation.
- R2: With `op_mode` = 2'b01 (pre-indexed), `mem_req_addr` equals base plus or minus offset. `wb_en` pulses for exactly one cycle with `wb_value` equal to that address. The pulse falls in the cycle after acceptance, while `mem_req_valid` is low, and `mem_req_valid` rises in the next cycle.
- R3: With `op_mode` = 2'b10 (post-indexed), `mem_req_addr` equals the unmodified base. `wb_en` asserts with `wb_value` = base plus or minus offset only in the cycle where `mem_req_valid` and `mem_req_ready` are both high.
- R4: `op_sub` = 0 adds the offset to the base, and `op_sub` = 1 subtracts it. The same rule applies to the address and to the writeback value.
- R5: All address arithmetic wraps modulo 2^AW (default 32), with no overflow indication.
- R6: `op_mode` = 2'b11 behaves as offset mode: the address is base plus or minus offset and `wb_en` stays low.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` hold their values into the next cycle.
- R8: A store (`op_is_load` = 0) issues `mem_req_write` = 1 with `mem_req_wdata` equal to the store data, and produces no `ld_valid`.
- R9: A load (`op_is_load` = 1) issues `mem_req_write` = 0. After its handshake, `ld_valid` asserts in the cycle `mem_rsp_valid` is high, with `ld_data` = `mem_rsp_data` and `ld_dest` = the operation's destination index.
- R10: After reset, `op_ready` = 1 and `mem_req_valid`, `wb_en` and `ld_valid` are 0. `op_ready` is high only when idle, so one operation is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle and able to accept |
| op_base | input | AW | Base register value |
| op_offset | input | AW | Resolved offset (immediate or register) |
| op_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| op_mode | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 treated as offset |
| op_is_load | input | 1 | 1 load, 0 store |
| op_wdata | input | DW | Store data |
| op_dest | input | RW | Load destination register index |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Effective address |
| mem_req_write | output | 1 | 1 for store |
| mem_req_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | DW | Returned load data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | DW | Load result data |
| ld_dest | output | RW | Load destination index |
| wb_en | output | 1 | Base writeback strobe |
| wb_value | output | AW | Base writeback value |

## Verification
The assertions assume that the memory side returns `mem_rsp_valid` only while a load is outstanding. They also assume that `op_*` fields are stable while `op_valid` is offered. The bench's memory model raises a response only after it has seen a load handshake. The driver keeps each operation's fields constant until the block accepts them. The ready pattern includes multi-cycle stalls so that the held-request and post-indexed timing properties are exercised across waiting cycles.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'b00,
        IDX_PRE    = 2'b01,
        IDX_POST   = 2'b10,
        IDX_RSVD   = 2'b11
    } idx_mode_e;

    typedef enum logic [1:0] {
        WB_NONE = 2'b00,
        WB_PRE  = 2'b01,
        WB_POST = 2'b10
    } wb_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_PREWB    = 2'b01,
        ST_REQ      = 2'b10,
        ST_WAIT_RSP = 2'b11
    } agu_state_e;

endpackage

// File: rtl/lsagu_addr_calc.sv
module lsagu_addr_calc
    import lsagu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          sub,
    input  logic [1:0]    mode,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] wb_val,
    output wb_kind_e      wb_kind
);

    logic [AW-1:0] off_inv;
    logic [AW-1:0] moved;

    // One adder serves both directions: subtract by inverting and adding one.
    assign off_inv = offset ^ {AW{sub}};
    assign moved   = base + off_inv + {{(AW-1){1'b0}}, sub};

    always_comb begin
        eff_addr = moved;
        wb_val   = moved;
        wb_kind  = WB_NONE;
        unique case (idx_mode_e'(mode))
            IDX_OFFSET: begin
                eff_addr = moved;
                wb_kind  = WB_NONE;
            end
            IDX_PRE: begin
                eff_addr = moved;
                wb_kind  = WB_PRE;
            end
            IDX_POST: begin
                eff_addr = base;
                wb_kind  = WB_POST;
            end
            IDX_RSVD: begin
                eff_addr = moved;
                wb_kind  = WB_NONE;
            end
            default: begin
                eff_addr = moved;
                wb_kind  = WB_NONE;
            end
        endcase
    end

endmodule

// File: rtl/lsagu_req_fsm.sv
module lsagu_req_fsm
    import lsagu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  wb_kind_e op_kind,
    input  logic     op_is_load,
    input  logic     mem_req_ready,
    input  logic     mem_rsp_valid,
    output logic     op_ready,
    output logic     accept,
    output logic     req_valid,
    output logic     wb_pulse,
    output logic     ld_fire
);

    agu_state_e state_q, state_d;
    wb_kind_e   kind_q;
    logic       load_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= WB_NONE;
            load_q <= 1'b0;
        end else if (accept) begin
            kind_q <= op_kind;
            load_q <= op_is_load;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    // ACCEPT_PRE or ACCEPT_DIRECT
                    state_d = (op_kind == WB_PRE) ? ST_PREWB : ST_REQ;
                end
            end
            ST_PREWB: begin
                // PREWB_DONE
                state_d = ST_REQ;
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    // LOAD_ISSUED or STORE_DONE
                    state_d = load_q ? ST_WAIT_RSP : ST_IDLE;
                end
            end
            ST_WAIT_RSP: begin
                if (mem_rsp_valid) begin
                    // LOAD_DONE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        op_ready  = 1'b0;
        req_valid = 1'b0;
        wb_pulse  = 1'b0;
        ld_fire   = 1'b0;
        unique case (state_q)
            ST_IDLE:     op_ready  = 1'b1;
            ST_PREWB:    wb_pulse  = 1'b1;
            ST_REQ: begin
                req_valid = 1'b1;
                wb_pulse  = mem_req_ready && (kind_q == WB_POST);
            end
            ST_WAIT_RSP: ld_fire   = mem_rsp_valid;
            default: begin
                op_ready  = 1'b0;
            end
        endcase
    end

    assign accept = op_ready && op_valid;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !mem_req_ready |=> req_valid);

    // R10
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !op_ready);

endmodule

// File: rtl/lsagu_req_hold.sv
module lsagu_req_hold #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] eff_addr,
    input  logic [AW-1:0] wb_val,
    input  logic          is_write,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] dest,
    input  logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] wb_q,
    output logic          write_q,
    output logic [DW-1:0] wdata_q,
    output logic [RW-1:0] dest_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wb_q    <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            dest_q  <= '0;
        end else if (load_en) begin
            addr_q  <= eff_addr;
            wb_q    <= wb_val;
            write_q <= is_write;
            wdata_q <= wdata;
            dest_q  <= dest;
        end
    end

    // R7
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(addr_q) && $stable(write_q) && $stable(wdata_q));

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
    import lsagu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [AW-1:0] op_base,
    input  logic [AW-1:0] op_offset,
    input  logic          op_sub,
    input  logic [1:0]    op_mode,
    input  logic          op_is_load,
    input  logic [DW-1:0] op_wdata,
    input  logic [RW-1:0] op_dest,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic          mem_req_write,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data,
    output logic [RW-1:0] ld_dest,
    output logic          wb_en,
    output logic [AW-1:0] wb_value
);

    logic [AW-1:0] calc_addr;
    logic [AW-1:0] calc_wb;
    wb_kind_e      calc_kind;
    logic          accept;

    lsagu_addr_calc #(.AW(AW)) u_calc (
        .base     (op_base),
        .offset   (op_offset),
        .sub      (op_sub),
        .mode     (op_mode),
        .eff_addr (calc_addr),
        .wb_val   (calc_wb),
        .wb_kind  (calc_kind)
    );

    lsagu_req_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_kind       (calc_kind),
        .op_is_load    (op_is_load),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .op_ready      (op_ready),
        .accept        (accept),
        .req_valid     (mem_req_valid),
        .wb_pulse      (wb_en),
        .ld_fire       (ld_valid)
    );

    lsagu_req_hold #(.AW(AW), .DW(DW), .RW(RW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .eff_addr  (calc_addr),
        .wb_val    (calc_wb),
        .is_write  (!op_is_load),
        .wdata     (op_wdata),
        .dest      (op_dest),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .addr_q    (mem_req_addr),
        .wb_q      (wb_value),
        .write_q   (mem_req_write),
        .wdata_q   (mem_req_wdata),
        .dest_q    (ld_dest)
    );

    assign ld_data = mem_rsp_data;

    // R3
    post_wb_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && mem_req_valid |-> mem_req_ready);

    // R2
    pre_wb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && !mem_req_valid |=> mem_req_valid && (mem_req_addr == $past(wb_value)));

    // R9
    ld_store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !mem_req_write && !mem_req_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req_valid && !wb_en && !ld_valid);

endmodule

// File: tb/test_lsagu_top.sv
module test_lsagu_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int RW = 4;
    localparam logic [DW-1:0] MEM_KEY = 32'h5A3C_0F96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [AW-1:0] op_base = '0;
    logic [AW-1:0] op_offset = '0;
    logic          op_sub = 1'b0;
    logic [1:0]    op_mode = 2'b00;
    logic          op_is_load = 1'b0;
    logic [DW-1:0] op_wdata = '0;
    logic [RW-1:0] op_dest = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_write;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          ld_valid;
    logic [DW-1:0] ld_data;
    logic [RW-1:0] ld_dest;
    logic          wb_en;
    logic [AW-1:0] wb_value;

    always #5 clk = ~clk;

    lsagu_top #(.AW(AW), .DW(DW), .RW(RW)) i_lsagu_top (.*);

    typedef struct {
        logic [AW-1:0] addr;
        logic          write;
        logic [DW-1:0] wdata;
        int            wbk;   // 0 none, 1 pre, 2 post
        logic [AW-1:0] wbv;
        string         tag;
    } req_item_t;

    typedef struct {
        logic [DW-1:0] data;
        logic [RW-1:0] dest;
    } ld_item_t;

    req_item_t req_q[$];
    req_item_t wb_q[$];
    ld_item_t  ld_q[$];

    int n_checks = 0;
    int n_fail = 0;
    int stall_en = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] b, input logic [AW-1:0] o, input logic s,
                         input logic [1:0] m, input logic ld, input logic [DW-1:0] wd,
                         input logic [RW-1:0] d, input string tag);
        req_item_t it;
        logic [AW-1:0] moved;
        ld_item_t li;
        moved = s ? (b - o) : (b + o);
        it.addr  = (m == 2'b10) ? b : moved;
        it.write = !ld;
        it.wdata = wd;
        it.wbk   = (m == 2'b01) ? 1 : ((m == 2'b10) ? 2 : 0);
        it.wbv   = moved;
        it.tag   = tag;
        req_q.push_back(it);
        if (it.wbk != 0) wb_q.push_back(it);
        if (ld) begin
            li.data = it.addr ^ MEM_KEY;
            li.dest = d;
            ld_q.push_back(li);
        end
        @(negedge clk);
        op_valid = 1'b1; op_base = b; op_offset = o; op_sub = s;
        op_mode = m; op_is_load = ld; op_wdata = wd; op_dest = d;
        #4;
        while (!op_ready) begin
            @(negedge clk);
            #4;
        end
    endtask

    // Monitor and memory model: drive at negedge, sample 1 ns before posedge.
    initial begin : monitor
        bit rsp_pend = 0;
        logic [DW-1:0] rsp_dat = '0;
        bit nxt_ready = 1;
        bit prev_stall = 0;
        logic [AW-1:0] p_addr = '0;
        logic p_write = 0;
        logic [DW-1:0] p_wdata = '0;
        int cyc = 0;
        forever begin
            @(negedge clk);
            mem_req_ready = nxt_ready;
            mem_rsp_valid = rsp_pend;
            mem_rsp_data  = rsp_pend ? rsp_dat : 32'hDEAD_BEEF;
            #4;
            if (rst_n) begin
                if (prev_stall) begin
                    chk(mem_req_valid && mem_req_addr == p_addr && mem_req_write == p_write
                        && mem_req_wdata == p_wdata, "R7 held request", {32'b0, mem_req_addr}, {32'b0, p_addr});
                end
                if (wb_en) begin
                    if (wb_q.size() == 0) begin
                        chk(0, "R1/R6 unexpected writeback", {32'b0, wb_value}, 64'h0);
                    end else begin
                        req_item_t w;
                        w = wb_q.pop_front();
                        chk(wb_value == w.wbv, {w.tag, " writeback value"}, {32'b0, wb_value}, {32'b0, w.wbv});
                        if (w.wbk == 1)
                            chk(!mem_req_valid, {w.tag, " R2 pre writeback before request"}, {63'b0, mem_req_valid}, 64'h0);
                        else
                            chk(mem_req_valid && mem_req_ready, {w.tag, " R3 post writeback at handshake"},
                                {63'b0, mem_req_ready}, 64'h1);
                    end
                end
                if (mem_req_valid && mem_req_ready) begin
                    if (req_q.size() == 0) begin
                        chk(0, "R10 unexpected request", {32'b0, mem_req_addr}, 64'h0);
                    end else begin
                        req_item_t r;
                        r = req_q.pop_front();
                        chk(mem_req_addr == r.addr, {r.tag, " address"}, {32'b0, mem_req_addr}, {32'b0, r.addr});
                        chk(mem_req_write == r.write, {r.tag, " R8/R9 direction"}, {63'b0, mem_req_write}, {63'b0, r.write});
                        if (r.write)
                            chk(mem_req_wdata == r.wdata, {r.tag, " R8 store data"}, {32'b0, mem_req_wdata}, {32'b0, r.wdata});
                        if (r.wbk == 0)
                            chk(!wb_en, {r.tag, " R1/R6 no writeback"}, {63'b0, wb_en}, 64'h0);
                        if (!r.write) begin
                            rsp_pend = 1;
                            rsp_dat  = mem_req_addr ^ MEM_KEY;
                        end
                    end
                end
                if (ld_valid) begin
                    if (ld_q.size() == 0) begin
                        chk(0, "R8 unexpected load result", {32'b0, ld_data}, 64'h0);
                    end else begin
                        ld_item_t l;
                        l = ld_q.pop_front();
                        chk(ld_data == l.data && ld_dest == l.dest, "R9 load result",
                            {28'b0, ld_dest, ld_data}, {28'b0, l.dest, l.data});
                    end
                    rsp_pend = 0;
                end
                prev_stall = mem_req_valid && !mem_req_ready;
                p_addr = mem_req_addr; p_write = mem_req_write; p_wdata = mem_req_wdata;
            end
            cyc++;
            nxt_ready = (stall_en != 0) ? ((cyc % 4) == 3) : 1'b1;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #4;
        // R10 reset state
        chk(op_ready == 1'b1, "R10 reset op_ready", {63'b0, op_ready}, 64'h1);
        chk(mem_req_valid == 1'b0, "R10 reset mem_req_valid", {63'b0, mem_req_valid}, 64'h0);
        chk(wb_en == 1'b0, "R10 reset wb_en", {63'b0, wb_en}, 64'h0);
        chk(ld_valid == 1'b0, "R10 reset ld_valid", {63'b0, ld_valid}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4 offset, add and subtract
        issue(32'h0000_1000, 32'h8, 1'b0, 2'b00, 1'b1, '0, 4'd2, "R1 offset add");
        issue(32'h0000_1000, 32'h8, 1'b1, 2'b00, 1'b0, 32'hCAFE_0001, 4'd0, "R4 offset sub");
        // R2 pre-indexed
        issue(32'h2000_0000, 32'h40, 1'b0, 2'b01, 1'b1, '0, 4'd5, "R2 pre add");
        issue(32'h2000_0000, 32'h40, 1'b1, 2'b01, 1'b0, 32'h1111_2222, 4'd0, "R2 pre sub");
        // R3 post-indexed
        issue(32'h3000_0010, 32'h4, 1'b0, 2'b10, 1'b1, '0, 4'd9, "R3 post add");
        issue(32'h3000_0010, 32'h4, 1'b1, 2'b10, 1'b0, 32'h3333_4444, 4'd0, "R3 post sub");
        // R6 reserved mode
        issue(32'h4000_0000, 32'hC, 1'b0, 2'b11, 1'b1, '0, 4'd7, "R6 reserved mode");
        // R5 wrap
        issue(32'hFFFF_FFF8, 32'h10, 1'b0, 2'b01, 1'b1, '0, 4'd1, "R5 wrap up");
        issue(32'h0000_0004, 32'h10, 1'b1, 2'b10, 1'b0, 32'h5555_6666, 4'd0, "R5 wrap down");
        // R7 stalls across modes
        @(negedge clk);
        stall_en = 1;
        issue(32'h5000_0100, 32'h20, 1'b0, 2'b10, 1'b0, 32'h7777_8888, 4'd0, "R3 post stalled");
        issue(32'h5000_0100, 32'h20, 1'b1, 2'b01, 1'b1, '0, 4'd15, "R2 pre stalled");
        issue(32'h6000_0000, 32'hFFFF_FFFF, 1'b0, 2'b00, 1'b0, 32'h9999_AAAA, 4'd0, "R7 offset stalled");
        issue(32'h7000_0000, 32'h100, 1'b0, 2'b11, 1'b1, '0, 4'd3, "R6 reserved stalled");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (30) @(negedge clk);
        #4;
        chk(req_q.size() == 0 && wb_q.size() == 0 && ld_q.size() == 0, "R10 all items drained",
            {32'b0, 10'b0, 22'(req_q.size() + wb_q.size() + ld_q.size())}, 64'h0);
        chk(op_ready == 1'b1, "R10 idle at end", {63'b0, op_ready}, 64'h1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule